// File: doc/BRIEF.md
# Half-Duplex Clocked Serial Link Transceiver

This block is the bit-level engine of a two-wire programming link: it drives a free-running link clock and a single shared data line that is driven while sending and released while listening. A clock-enable input advances the link clock by one half period per tick, and the clock keeps running whether or not a frame is in flight.

On the byte side, a one-cycle strobe queues a byte to send, a break frame, or the reception of one byte. Each transfer is a 12-bit frame, shifted least significant bit first. The frame holds a low start bit, eight data bits, an even parity bit and two high stop bits. Outgoing bits change on falling link-clock edges. Incoming bits are sampled on rising edges, after a hunt for the start bit. Reversing direction turns the data line around cleanly. A request that arrives during a frame waits in a one-entry slot until the bit counter is empty.

Top module: `hdx_serial_phy`

## Requirements
- R1: `linkClk` inverts in the cycle after every cycle with `bitTick` high and holds otherwise, including while `busy` is low.
- R2: A send shifts out 12 bits, bit 0 first: bit 0 is 0 (start), bits 1..8 are the byte from its bit 0 to bit 7, bit 9 is parity, and bits 10 and 11 are 1 (stop).
- R3: The parity bit is 1 exactly when the byte has an odd number of ones.
- R4: While driving, `dataOut` changes only together with a falling `linkClk` edge. While receiving, the line is sampled only at rising edges, so `rxValid` rises together with a rising `linkClk`.
- R5: While a receive waits for its first bit, a high line is skipped; the frame starts at the first low sample.
- R6: After 12 received bits, `rxValid` pulses for one cycle with `rxByte` holding received bits 1..8. Bits 9..11 are dropped, and a wrong parity bit still yields the byte.
- R7: A break request shifts out 12 bits that are all 1.
- R8: When a send or break follows a receive, `dataOe` turns on with `dataOut` already high.
- R9: A receive requested during a send waits for the frame to end, and only then does `dataOe` fall.
- R10: `busy` is high exactly while the bit counter is non-zero; one frame spans exactly 12 falling (send) or taken rising (receive) edges.
- R11: A request made while `busy` is held and started once the link is idle, so two back-to-back sends yield two whole frames in order.
- R12: After reset `linkClk` is 0, `dataOe` is 0, `dataOut` is 1, and `busy` and `rxValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Clock-enable: one link-clock half period per pulse |
| sendByte | input | 8 | Byte to send, taken with `sendStb` |
| sendStb | input | 1 | Queue a data frame |
| breakStb | input | 1 | Queue a break frame (wins over `sendStb`) |
| recvStb | input | 1 | Queue reception of one frame |
| dataIn | input | 1 | Sampled level of the data line |
| linkClk | output | 1 | Link clock |
| dataOut | output | 1 | Value driven on the data line |
| dataOe | output | 1 | Data line driver enable |
| rxByte | output | 8 | Last received data byte |
| rxValid | output | 1 | One-cycle pulse with a new `rxByte` |
| busy | output | 1 | Frame in progress |

## Verification
Random bytes are sent with both parities, so a fault in the parity or a misplaced data bit shows in the captured frame. Break frames, where only the all-ones pattern and the 12-bit length can be seen, are mixed in among them. Receives use a random number of leading high bits, which separates a correct start hunt from one that latches too early. Some receives carry a deliberately wrong parity bit to show that no check is made. Send, receive, send sequences and strobes issued during a busy frame test the turnaround order and the queuing of a held request.

// File: rtl/phy_pkg.sv
package phy_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_SEND = 2'd1,
    REQ_BRK  = 2'd2,
    REQ_RECV = 2'd3
  } reqKind_t;

  typedef struct packed {
    logic latchByte;
    logic loadTx;
    logic loadBrk;
    logic loadRx;
    logic txStep;
    logic rxStep;
    logic rxLast;
  } phyStrobes_t;
endpackage

// File: rtl/phy_ctrl.sv
module phy_ctrl
  import phy_pkg::*;
#(
  parameter int FRAME_W = 12,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        sendStb,
  input  logic        breakStb,
  input  logic        recvStb,
  input  logic        dataIn,
  output logic        linkClk,
  output logic        dataOe,
  output logic        busy,
  output phyStrobes_t stb
);
  reqKind_t   pending;
  reqKind_t   newReq;
  logic [CNT_W-1:0] bitCnt;
  logic       isTx;
  logic       launch;
  logic       riseEv;
  logic       fallEv;
  logic       hunting;

  assign busy    = (bitCnt != '0);
  assign riseEv  = bitTick && !linkClk;
  assign fallEv  = bitTick && linkClk;
  assign launch  = (pending != REQ_NONE) && !busy;
  assign hunting = (bitCnt == CNT_W'(FRAME_W));

  always_comb begin
    if (breakStb)     newReq = REQ_BRK;
    else if (sendStb) newReq = REQ_SEND;
    else if (recvStb) newReq = REQ_RECV;
    else              newReq = REQ_NONE;
  end

  always_comb begin
    stb.latchByte = (pending == REQ_NONE) && sendStb && !breakStb;
    stb.loadTx    = launch && (pending == REQ_SEND);
    stb.loadBrk   = launch && (pending == REQ_BRK);
    stb.loadRx    = launch && (pending == REQ_RECV);
    stb.txStep    = fallEv && isTx && busy;
    stb.rxStep    = riseEv && !isTx && busy && !(hunting && dataIn);
    stb.rxLast    = stb.rxStep && (bitCnt == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkClk <= 1'b0;
      pending <= REQ_NONE;
      bitCnt  <= '0;
      isTx    <= 1'b0;
      dataOe  <= 1'b0;
    end else begin
      if (bitTick) linkClk <= !linkClk;
      if (launch)                  pending <= REQ_NONE;
      else if (pending == REQ_NONE) pending <= newReq;
      if (launch) begin
        bitCnt <= CNT_W'(FRAME_W);
        isTx   <= (pending != REQ_RECV);
        dataOe <= (pending != REQ_RECV);
      end else if (stb.txStep || stb.rxStep) begin
        bitCnt <= bitCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_datapath.sv
module phy_datapath
  import phy_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  phyStrobes_t       stb,
  input  logic [DATA_W-1:0] sendByte,
  input  logic              dataIn,
  output logic              dataOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid
);
  logic [DATA_W-1:0]  holdByte;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] txFrame;
  logic [FRAME_W-1:0] rxNext;

  assign txFrame = {2'b11, ^holdByte, holdByte, 1'b0};
  assign rxNext  = {1'b0, dataIn, shiftReg[FRAME_W-2:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
      shiftReg <= '0;
      dataOut  <= 1'b1;
      rxByte   <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= stb.rxLast;
      if (stb.latchByte) holdByte <= sendByte;
      if (stb.loadTx) begin
        shiftReg <= txFrame;
        dataOut  <= 1'b1;
      end else if (stb.loadBrk) begin
        shiftReg <= '1;
        dataOut  <= 1'b1;
      end else if (stb.loadRx) begin
        shiftReg <= '0;
      end else if (stb.txStep) begin
        dataOut  <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (stb.rxStep) begin
        shiftReg <= rxNext;
        if (stb.rxLast) rxByte <= rxNext[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/hdx_serial_phy.sv
module hdx_serial_phy
  import phy_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_W = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic [DATA_W-1:0] sendByte,
  input  logic              sendStb,
  input  logic              breakStb,
  input  logic              recvStb,
  input  logic              dataIn,
  output logic              linkClk,
  output logic              dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              busy
);
  phyStrobes_t stb;

  phy_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .sendStb(sendStb),
    .breakStb(breakStb), .recvStb(recvStb), .dataIn(dataIn),
    .linkClk(linkClk), .dataOe(dataOe), .busy(busy), .stb(stb)
  );

  phy_datapath #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sendByte(sendByte), .dataIn(dataIn),
    .dataOut(dataOut), .rxByte(rxByte), .rxValid(rxValid)
  );
endmodule

// File: rtl/phy_checker.sv
module phy_checker (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic linkClk,
  input logic dataOut,
  input logic dataOe,
  input logic busy,
  input logic rxValid
);
  // R1
  tick_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> (linkClk != $past(linkClk)));
  // R1
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(linkClk));
  // R4
  tx_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe) && !$stable(dataOut)) |-> $fell(linkClk));
  // R4
  rx_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $rose(linkClk));
  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  // R8
  turn_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> dataOut);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataOe) |-> !$past(busy));
endmodule

bind hdx_serial_phy phy_checker u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .linkClk(linkClk),
  .dataOut(dataOut), .dataOe(dataOe), .busy(busy), .rxValid(rxValid)
);

// File: tb/sim_hdx_serial_phy.sv
module sim_hdx_serial_phy;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic [7:0] sendByte = '0;
  logic       sendStb = 1'b0;
  logic       breakStb = 1'b0;
  logic       recvStb = 1'b0;
  logic       dataIn = 1'b1;
  logic       linkClk, dataOut, dataOe, rxValid, busy;
  logic [7:0] rxByte;

  int checks = 0;
  int fails = 0;

  // bench monitor state
  logic [31:0] txBuf;
  int   txCnt = 0;
  logic rxGot = 1'b0;
  logic [7:0] rxData;
  logic prevClk = 1'b0, prevBusy = 1'b0, prevOe = 1'b0, prevOut = 1'b1;
  logic oeRoseOut = 1'b0;
  logic oeFellBusy = 1'b0;
  int   edgeViol = 0;
  int   tickCnt = 0;
  int   toggleCnt = 0;

  always #5 clk = !clk;

  hdx_serial_phy u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .sendByte(sendByte),
    .sendStb(sendStb), .breakStb(breakStb), .recvStb(recvStb), .dataIn(dataIn),
    .linkClk(linkClk), .dataOut(dataOut), .dataOe(dataOe), .rxByte(rxByte),
    .rxValid(rxValid), .busy(busy)
  );

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div == 2) ? 0 : div + 1;
      bitTick = (div == 0);
      if (bitTick && rstN) tickCnt++;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (linkClk != prevClk) toggleCnt++;
      if (prevClk && !linkClk && prevBusy && dataOe && txCnt < 32) begin
        txBuf[txCnt] = dataOut;
        txCnt++;
      end
      if (dataOe && prevOe && dataOut != prevOut && !(prevClk && !linkClk)) edgeViol++;
      if (dataOe && !prevOe) oeRoseOut = dataOut;
      if (!dataOe && prevOe) oeFellBusy = prevBusy;
      if (rxValid) begin
        rxGot = 1'b1;
        rxData = rxByte;
      end
    end
    prevClk = linkClk; prevBusy = busy; prevOe = dataOe; prevOut = dataOut;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [11:0] expFrame(input logic [7:0] b);
    return {2'b11, ^b, b, 1'b0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input int kind, input logic [7:0] b);
    @(negedge clk);
    sendByte = b;
    sendStb = (kind == 0);
    breakStb = (kind == 1);
    recvStb = (kind == 2);
    @(negedge clk);
    sendStb = 1'b0; breakStb = 1'b0; recvStb = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitFall();
    logic p;
    p = linkClk;
    forever begin
      @(negedge clk);
      if (p && !linkClk) break;
      p = linkClk;
    end
  endtask

  task automatic sendCheck(input logic [7:0] b);
    logic [11:0] f;
    txCnt = 0;
    strobe(0, b);
    waitIdle();
    f = txBuf[11:0];
    check(txCnt == 12, "R10 send length", txCnt, 12);
    check(f == expFrame(b), "R2 frame", f, expFrame(b));
    check(f[9] == (^b), "R3 parity", f[9], ^b);
  endtask

  task automatic recvCheck(input logic [7:0] b, input int idles, input bit badPar);
    logic [11:0] f;
    f = expFrame(b);
    if (badPar) f[9] = !f[9];
    rxGot = 1'b0;
    strobe(2, 8'h00);
    while (dataOe || !busy) @(negedge clk);
    for (int i = 0; i < idles; i++) begin
      waitFall();
      dataIn = 1'b1;
    end
    for (int i = 0; i < 12; i++) begin
      waitFall();
      dataIn = f[i];
    end
    waitFall();
    dataIn = 1'b1;
    waitIdle();
    check(rxGot, "R6 rxValid seen", rxGot, 1);
    if (badPar) check(rxData == b, "R6 byte with bad parity", rxData, b);
    else check(rxData == b, "R5 byte after idle highs", rxData, b);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (4) @(negedge clk);
    // R12 reset state
    check(linkClk == 0 && dataOe == 0 && dataOut == 1 && busy == 0 && rxValid == 0,
          "R12 reset state", {linkClk, dataOe, dataOut, busy, rxValid}, 5'b00100);
    rstN = 1'b1;
    @(negedge clk);
    tickCnt = 0; toggleCnt = 0;
    repeat (60) @(negedge clk);
    // R1 idle clock keeps running
    check((toggleCnt >= tickCnt - 1) && (toggleCnt <= tickCnt + 1) && tickCnt > 10,
          "R1 idle toggles", toggleCnt, tickCnt);

    sendCheck(8'h00);
    sendCheck(8'hFF);
    sendCheck(8'h01);
    sendCheck(8'h80);
    for (int i = 0; i < 30; i++) sendCheck(8'($urandom));

    // R7 break frame
    txCnt = 0;
    strobe(1, 8'h00);
    waitIdle();
    check(txCnt == 12, "R7 break length", txCnt, 12);
    check(txBuf[11:0] == 12'hFFF, "R7 break pattern", txBuf[11:0], 12'hFFF);

    // R11 held request
    txCnt = 0;
    strobe(0, 8'hA5);
    repeat (20) @(negedge clk);
    strobe(0, 8'h3C);
    waitIdle();
    waitIdle();
    check(txCnt == 24, "R11 two frames length", txCnt, 24);
    check(txBuf[11:0] == expFrame(8'hA5), "R11 first frame", txBuf[11:0], expFrame(8'hA5));
    check(txBuf[23:12] == expFrame(8'h3C), "R11 second frame", txBuf[23:12], expFrame(8'h3C));

    // R9 receive requested during a send
    txCnt = 0;
    strobe(0, 8'h96);
    repeat (10) @(negedge clk);
    recvCheck(8'h5A, 2, 1'b0);
    check(txCnt == 12, "R9 send finished before turnaround", txCnt, 12);
    check(oeFellBusy == 1'b0, "R9 released only when idle", oeFellBusy, 0);

    recvCheck(8'h00, 0, 1'b0);
    recvCheck(8'hFF, 5, 1'b0);
    recvCheck(8'h81, 3, 1'b1);
    for (int i = 0; i < 12; i++) recvCheck(8'($urandom), int'($urandom % 6), 1'($urandom));

    // R8 turnaround back to driving
    oeRoseOut = 1'b0;
    sendCheck(8'h42);
    check(oeRoseOut == 1'b1, "R8 line high at enable", oeRoseOut, 1);

    // R4 driven line changes only on falling edges
    check(edgeViol == 0, "R4 edge violations", edgeViol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule